// File: doc/BRIEF.md
# Gain-Scheduled Line-Lock Loop Filter

This block is the digital loop filter of a clock recovery loop that locks a sample clock to incoming video lines. Once per line, a phase detector presents a signed phase error together with a one-cycle strobe. The filter turns that error into a frequency-control word for a numerically controlled oscillator. The word is centred on a programmed nominal count of sample clocks per line. A proportional term scaled by gain A and a saturating integral term scaled by gain B are added to that nominal count.

The filter holds three gain sets, one for each bandwidth range, from widest (0) to narrowest (2). Each gain is written as an unsigned mantissa and an exponent. A run of quiet lines, where the error magnitude stays at or below a threshold, moves the filter one range narrower. A single noisy line moves it one range wider at once. All gains, thresholds and the nominal count are plain register inputs. They are sampled on the line strobe.

Top module: `llk_loop_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `range_o` is 0 (widest), `freq_word` is 0 and `word_upd` is 0. The integral accumulator starts from 0.
- R2: On a line the proportional term is floor(err × Am × 2^Ae / 256). The gain set used is the one belonging to the range in force when the line arrives. Set k sits at bits [k*8 +: 8] of the mantissa buses and bits [k*3 +: 3] of the exponent buses.
- R3: On each line the integral accumulator adds floor(err × Bm × 2^Be / 256). It saturates at −524288 and +524287.
- R4: `freq_word` = nominal + proportional term + updated integral. The result is clamped to the range 0 to 65535.
- R5: When the error magnitude is at most `quiet_thr` on `quiet_lines` consecutive lines, the range steps one narrower on the line that completes the run. A count of 0 acts like 1.
- R6: A line whose error magnitude exceeds `quiet_thr` steps the range one wider. The new range is visible together with that line's word.
- R7: A noisy line in the widest range leaves the range at 0.
- R8: The range never goes beyond 2. Quiet lines in the narrowest range leave it there.
- R9: The quiet-line run restarts after any range change and after any noisy line.
- R10: `word_upd` pulses for exactly the one cycle after each strobe. `freq_word` and `range_o` do not change in any other cycle, whatever `phase_err` does between strobes.
- R11: The error magnitude is exact over the whole input range. An error of −2048 exceeds a threshold of 2047, while +2047 does not exceed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle strobe marking a new line's error |
| phase_err | input | 12 | Signed phase error, valid with `line_stb` |
| nominal_clks | input | 16 | Nominal sample clocks per line |
| prop_mant_all | input | 24 | Proportional mantissas, set k at [k*8 +: 8] |
| prop_exp_all | input | 9 | Proportional exponents, set k at [k*3 +: 3] |
| integ_mant_all | input | 24 | Integral mantissas, set k at [k*8 +: 8] |
| integ_exp_all | input | 9 | Integral exponents, set k at [k*3 +: 3] |
| quiet_thr | input | 12 | Unsigned error-magnitude threshold |
| quiet_lines | input | 8 | Quiet lines needed to narrow the range |
| freq_word | output | 16 | Oscillator frequency-control word |
| word_upd | output | 1 | Pulses when `freq_word` has been refreshed |
| range_o | output | 2 | Current bandwidth range, 0 widest |

## Verification
The hardest state to reach from the ports is the pair of rails: the integral accumulator pinned at its limit while the output word is clamped at a different limit. Errors near full scale alone never get there. The stimulus first holds the filter in the widest range with noisy lines. It then loads that range's gains with the largest mantissa and exponent and drives several full-scale positive lines, followed by full-scale negative lines. This walks the integral through both saturation points and the word through both clamps. The quiet-run logic is stressed by breaking a run one line short of its target and checking that the count starts again.

// File: rtl/llf_pkg.sv
package llf_pkg;

  localparam int LLF_NRANGE = 3;

  typedef enum logic [1:0] {
    RNG_WIDE   = 2'd0,
    RNG_MID    = 2'd1,
    RNG_NARROW = 2'd2
  } llf_range_e;

endpackage

// File: rtl/llf_shift.sv
// Arithmetic barrel shifter: left by a variable exponent, then a fixed
// arithmetic right shift that removes the fractional scaling.
module llf_shift #(
  parameter int IN_W  = 21,
  parameter int EXP_W = 3,
  parameter int FRAC  = 8
) (
  input  logic signed [IN_W-1:0]                  din,
  input  logic        [EXP_W-1:0]                 sh,
  output logic signed [IN_W+(1<<EXP_W)-2:0]       dout
);
  localparam int SH_W = IN_W + (1 << EXP_W) - 1;

  logic signed [SH_W-1:0] stage [0:EXP_W];

  assign stage[0] = SH_W'(din);

  for (genvar k = 0; k < EXP_W; k++) begin : g_stage
    assign stage[k+1] = sh[k] ? (stage[k] <<< (1 << k)) : stage[k];
  end

  assign dout = stage[EXP_W] >>> FRAC;

endmodule

// File: rtl/llf_gain_term.sv
// err * (mant * 2^exp) / 2^FRAC, floor rounding.
module llf_gain_term #(
  parameter int ERR_W  = 12,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 3,
  parameter int FRAC   = 8
) (
  input  logic signed [ERR_W-1:0]                    err,
  input  logic        [MANT_W-1:0]                   mant,
  input  logic        [EXP_W-1:0]                    expo,
  output logic signed [ERR_W+MANT_W+(1<<EXP_W)-1:0]  term
);
  localparam int PROD_W = ERR_W + MANT_W + 1;

  logic signed [PROD_W-1:0] prod;

  assign prod = PROD_W'(err) * PROD_W'($signed({1'b0, mant}));

  llf_shift #(
    .IN_W (PROD_W),
    .EXP_W(EXP_W),
    .FRAC (FRAC)
  ) u_shift (
    .din (prod),
    .sh  (expo),
    .dout(term)
  );

endmodule

// File: rtl/llf_range_ctrl.sv
// Bandwidth range scheduler driven by a run of quiet lines.
module llf_range_ctrl
  import llf_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic signed [ERR_W-1:0] err,
  input  logic        [ERR_W-1:0] thr,
  input  logic        [CNT_W-1:0] need,
  output llf_range_e              range_q
);
  logic [ERR_W-1:0] mag;
  logic             noisy;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             run_done;

  assign mag      = err[ERR_W-1] ? (~err + 1'b1) : err;
  assign noisy    = mag > thr;
  assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign run_done = cnt_inc >= {1'b0, need};

  always_ff @(posedge clk) begin
    if (rst) begin
      range_q <= RNG_WIDE;
      cnt_q   <= '0;
    end else if (stb) begin
      if (noisy) begin
        cnt_q <= '0;
        if (range_q != RNG_WIDE) range_q <= llf_range_e'(range_q - 2'd1);
      end else if (range_q != RNG_NARROW) begin
        if (run_done) begin
          range_q <= llf_range_e'(range_q + 2'd1);
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/llf_accum.sv
// Saturating integrator and output word assembly.
module llf_accum #(
  parameter int TERM_W = 28,
  parameter int INT_W  = 20,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic        [WORD_W-1:0] nominal,
  input  logic signed [TERM_W-1:0] pterm,
  input  logic signed [TERM_W-1:0] iterm,
  output logic        [WORD_W-1:0] word_q,
  output logic                     upd_q
);
  localparam int BIG_W = (TERM_W > INT_W) ? TERM_W : INT_W;
  localparam int ACC_W = BIG_W + WORD_W + 3;

  localparam logic signed [ACC_W-1:0] IMAX = {{(ACC_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] IMIN = {{(ACC_W-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] WMAX = {{(ACC_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic signed [INT_W-1:0]  integ_q;
  logic signed [ACC_W-1:0]  isum;
  logic signed [ACC_W-1:0]  integ_n;
  logic signed [ACC_W-1:0]  wsum;
  logic        [WORD_W-1:0] word_n;

  always_comb begin
    isum = ACC_W'(integ_q) + ACC_W'(iterm);
    if (isum > IMAX)      integ_n = IMAX;
    else if (isum < IMIN) integ_n = IMIN;
    else                  integ_n = isum;

    wsum = ACC_W'($signed({1'b0, nominal})) + ACC_W'(pterm) + integ_n;
    if (wsum < 0)         word_n = '0;
    else if (wsum > WMAX) word_n = '1;
    else                  word_n = wsum[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      word_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= stb;
      if (stb) begin
        integ_q <= integ_n[INT_W-1:0];
        word_q  <= word_n;
      end
    end
  end

endmodule

// File: rtl/llk_loop_filter.sv
module llk_loop_filter
  import llf_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 3,
  parameter int FRAC   = 8,
  parameter int WORD_W = 16,
  parameter int INT_W  = 20,
  parameter int CNT_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           line_stb,
  input  logic signed [ERR_W-1:0]        phase_err,
  input  logic [WORD_W-1:0]              nominal_clks,
  input  logic [LLF_NRANGE*MANT_W-1:0]   prop_mant_all,
  input  logic [LLF_NRANGE*EXP_W-1:0]    prop_exp_all,
  input  logic [LLF_NRANGE*MANT_W-1:0]   integ_mant_all,
  input  logic [LLF_NRANGE*EXP_W-1:0]    integ_exp_all,
  input  logic [ERR_W-1:0]               quiet_thr,
  input  logic [CNT_W-1:0]               quiet_lines,
  output logic [WORD_W-1:0]              freq_word,
  output logic                           word_upd,
  output logic [1:0]                     range_o
);
  localparam int TERM_W = ERR_W + MANT_W + (1 << EXP_W);

  llf_range_e               cur_range;
  logic [MANT_W-1:0]        a_mant, b_mant;
  logic [EXP_W-1:0]         a_exp,  b_exp;
  logic signed [TERM_W-1:0] pterm,  iterm;

  assign a_mant = prop_mant_all [cur_range*MANT_W +: MANT_W];
  assign a_exp  = prop_exp_all  [cur_range*EXP_W  +: EXP_W];
  assign b_mant = integ_mant_all[cur_range*MANT_W +: MANT_W];
  assign b_exp  = integ_exp_all [cur_range*EXP_W  +: EXP_W];

  llf_gain_term #(
    .ERR_W(ERR_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .FRAC(FRAC)
  ) u_prop (
    .err (phase_err),
    .mant(a_mant),
    .expo(a_exp),
    .term(pterm)
  );

  llf_gain_term #(
    .ERR_W(ERR_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .FRAC(FRAC)
  ) u_integ (
    .err (phase_err),
    .mant(b_mant),
    .expo(b_exp),
    .term(iterm)
  );

  llf_accum #(
    .TERM_W(TERM_W), .INT_W(INT_W), .WORD_W(WORD_W)
  ) u_accum (
    .clk    (clk),
    .rst    (rst),
    .stb    (line_stb),
    .nominal(nominal_clks),
    .pterm  (pterm),
    .iterm  (iterm),
    .word_q (freq_word),
    .upd_q  (word_upd)
  );

  llf_range_ctrl #(
    .ERR_W(ERR_W), .CNT_W(CNT_W)
  ) u_range (
    .clk    (clk),
    .rst    (rst),
    .stb    (line_stb),
    .err    (phase_err),
    .thr    (quiet_thr),
    .need   (quiet_lines),
    .range_q(cur_range)
  );

  assign range_o = cur_range;

endmodule

// File: rtl/llf_checker.sv
module llf_checker #(
  parameter int ERR_W  = 12,
  parameter int WORD_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    line_stb,
  input logic signed [ERR_W-1:0] phase_err,
  input logic        [ERR_W-1:0] quiet_thr,
  input logic        [WORD_W-1:0] freq_word,
  input logic                    word_upd,
  input logic        [1:0]       range_o
);
  logic [ERR_W:0] err_abs;
  logic           loud;

  always_comb begin
    if (phase_err < 0) err_abs = -{phase_err[ERR_W-1], phase_err};
    else               err_abs = {1'b0, phase_err};
    loud = err_abs > {1'b0, quiet_thr};
  end

  // R10
  upd_after_line_chk: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> word_upd);

  // R10
  no_stray_upd_chk: assert property (@(posedge clk) disable iff (rst)
    !line_stb |=> !word_upd);

  // R10
  word_held_chk: assert property (@(posedge clk) disable iff (rst)
    !word_upd |-> $stable(freq_word));

  // R10
  range_moves_on_line_chk: assert property (@(posedge clk) disable iff (rst)
    (range_o != $past(range_o)) |-> $past(line_stb));

  // R8
  range_legal_chk: assert property (@(posedge clk) disable iff (rst)
    range_o <= 2'd2);

  // R6
  fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (line_stb && loud && range_o != 2'd0) |=> (range_o == $past(range_o) - 2'd1));

  // R7
  widest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_stb && loud && range_o == 2'd0) |=> (range_o == 2'd0));

endmodule

bind llk_loop_filter llf_checker #(
  .ERR_W (ERR_W),
  .WORD_W(WORD_W)
) u_llf_chk (
  .clk      (clk),
  .rst      (rst),
  .line_stb (line_stb),
  .phase_err(phase_err),
  .quiet_thr(quiet_thr),
  .freq_word(freq_word),
  .word_upd (word_upd),
  .range_o  (range_o)
);

// File: tb/sim_llk_loop_filter.sv
module sim_llk_loop_filter;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              line_stb = 1'b0;
  logic signed [11:0] phase_err = '0;
  logic [15:0]       nominal_clks = 16'd1000;
  logic [23:0]       prop_mant_all = '0;
  logic [8:0]        prop_exp_all = '0;
  logic [23:0]       integ_mant_all = '0;
  logic [8:0]        integ_exp_all = '0;
  logic [11:0]       quiet_thr = 12'd20;
  logic [7:0]        quiet_lines = 8'd3;
  logic [15:0]       freq_word;
  logic              word_upd;
  logic [1:0]        range_o;

  always #(CLK_P/2) clk = ~clk;

  llk_loop_filter u0 (
    .clk(clk), .rst(rst), .line_stb(line_stb), .phase_err(phase_err),
    .nominal_clks(nominal_clks), .prop_mant_all(prop_mant_all),
    .prop_exp_all(prop_exp_all), .integ_mant_all(integ_mant_all),
    .integ_exp_all(integ_exp_all), .quiet_thr(quiet_thr),
    .quiet_lines(quiet_lines), .freq_word(freq_word),
    .word_upd(word_upd), .range_o(range_o)
  );

  typedef struct {
    longint w;
    int     r;
    string  tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_chk = 0;
  int     n_bad = 0;

  int     am[3], ae[3], bm[3], be[3];
  int     m_range = 0;
  int     m_cnt = 0;
  longint m_integ = 0;

  function automatic longint gterm(int e, int m, int x);
    longint p;
    p = longint'(e) * longint'(m);
    p = p <<< x;
    return p >>> 8;
  endfunction

  task automatic check(string tag, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic load_coefs();
    for (int k = 0; k < 3; k++) begin
      prop_mant_all[k*8 +: 8]  = am[k][7:0];
      prop_exp_all[k*3 +: 3]   = ae[k][2:0];
      integ_mant_all[k*8 +: 8] = bm[k][7:0];
      integ_exp_all[k*3 +: 3]  = be[k][2:0];
    end
  endtask

  // Driver: model the expected result, queue it, then present the line.
  task automatic apply_line(int e, string tag);
    exp_t   it;
    int     mag;
    int     r;
    longint w;
    r   = m_range;
    mag = (e < 0) ? -e : e;
    m_integ = m_integ + gterm(e, bm[r], be[r]);
    if (m_integ > 524287)  m_integ = 524287;
    if (m_integ < -524288) m_integ = -524288;
    w = longint'(nominal_clks) + gterm(e, am[r], ae[r]) + m_integ;
    if (w < 0)     w = 0;
    if (w > 65535) w = 65535;
    if (mag > int'(quiet_thr)) begin
      m_cnt = 0;
      if (m_range > 0) m_range--;
    end else if (m_range < 2) begin
      if (m_cnt + 1 >= int'(quiet_lines)) begin
        m_range++;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end else begin
      m_cnt = 0;
    end
    it.w = w; it.r = m_range; it.tag = tag;
    load_coefs();
    @(negedge clk);
    exp_q.push_back(it);
    line_stb  = 1'b1;
    phase_err = 12'(e);
    @(negedge clk);
    line_stb  = 1'b0;
  endtask

  // Monitor: compare each refreshed result against the queue.
  always @(negedge clk) begin
    if (!rst && word_upd) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: actual update with no line pending, expected none");
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.tag, " word"}, longint'(freq_word), it.w);
        check({it.tag, " range"}, longint'(range_o), longint'(it.r));
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual run still going, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    am = '{200, 100, 60}; ae = '{2, 1, 0};
    bm = '{40, 10, 3};    be = '{1, 1, 0};
    load_coefs();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 word in reset", longint'(freq_word), 0);
    check("R1 range in reset", longint'(range_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 word after reset", longint'(freq_word), 0);
    check("R1 range after reset", longint'(range_o), 0);
    check("R1 upd after reset", longint'(word_upd), 0);

    // R5: three quiet lines step to range 1; R2 uses set 0 meanwhile
    apply_line(10, "R2");
    apply_line(-5, "R2");
    apply_line(15, "R5");
    // R6: a noisy line falls back in the same line
    apply_line(25, "R6");
    // R7: noisy in the widest range stays there
    apply_line(-30, "R7");
    // R9: a run broken one line short must restart
    apply_line(3, "R9");
    apply_line(4, "R9");
    apply_line(40, "R9");
    apply_line(-2, "R9");
    apply_line(1, "R9");
    apply_line(0, "R5");
    // walk to the narrowest range and hold
    apply_line(7, "R3");
    apply_line(-8, "R3");
    apply_line(9, "R5");
    apply_line(-20, "R8");
    apply_line(20, "R8");
    apply_line(5, "R8");
    apply_line(6, "R8");
    // R6 from the narrowest range
    apply_line(-21, "R6");
    // R5: a count of 0 behaves like 1
    quiet_lines = 8'd0;
    apply_line(2, "R5");
    apply_line(-3, "R8");
    // R11: magnitude boundaries
    quiet_thr = 12'd2047;
    apply_line(2047, "R11");
    apply_line(-2048, "R11");
    apply_line(-2048, "R11");

    // R3/R4: saturate integral and word in both directions in range 0
    quiet_thr   = 12'd20;
    quiet_lines = 8'd200;
    apply_line(-2048, "R7");
    am[0] = 255; ae[0] = 7; bm[0] = 255; be[0] = 7;
    for (int i = 0; i < 5; i++) apply_line(2047, "R4");
    for (int i = 0; i < 8; i++) apply_line(-2048, "R3");
    for (int i = 0; i < 3; i++) apply_line(600, "R4");

    // R10: error wiggles between lines change nothing
    repeat (2) @(negedge clk);
    begin
      logic [15:0] held_w;
      logic [1:0]  held_r;
      held_w = freq_word;
      held_r = range_o;
      for (int i = 0; i < 6; i++) begin
        phase_err = 12'(i * 397 - 1000);
        @(negedge clk);
        check("R10 word held", longint'(freq_word), longint'(held_w));
        check("R10 range held", longint'(range_o), longint'(held_r));
        check("R10 no update", longint'(word_upd), 0);
      end
    end

    repeat (3) @(negedge clk);
    check("R10 all lines answered", longint'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule